// File: doc/BRIEF.md
# Dual-Register Logic Macrocell

This block is one output cell of a sum-of-products programmable logic fabric. It receives the product terms that the AND array produces for it, a static configuration word, the dedicated clock pin and the cell's own pin input. It returns the pin output value, a tri-state enable, and the signals the cell feeds back into the array.

Five of the product terms are control terms: two clock terms, two asynchronous-reset terms and an output enable. The rest are ORed in groups of four into three sum terms. The configuration steers those sum terms to the two flip-flops and to the combinatorial output. It also picks D or T behaviour for each flip-flop, whether each clock term is gated by the clock pin, whether the pin is driven from register 1 or from the combinatorial sum, the output polarity, and whether the second feedback carries register 2's output or its raw input.

The whole fabric runs on one system clock `clk`. A product-term clock is an edge event: a register is clocked at the system edge where its effective clock is high and was low at the previous system edge. The reset and preset terms are sampled at the same edges. Combinatorial output and feedback paths respond in the same cycle.

Top module: `mcell_macrocell`

## Requirements
- R1: While `rst_n` is low, both registers and both clock-edge trackers are cleared. After release with no stimulus, q1Pair = 2'b10, fb2Pair = 2'b10, and padOut = 0 with active-high polarity in registered mode.
- R2: Product-term positions: bit 0 reset 1, bit 1 clock 1, bit 2 clock 2, bit 3 reset 2, bit 4 output enable. Sum term A = OR of bits 8:5, B = OR of bits 12:9, C = OR of bits 16:13.
- R3: In registered mode (cfgWord[0]=0), register 2's input is C. Register 1's input is A|B when cfgWord[3]=0, and A|B|C when cfgWord[3]=1.
- R4: In combinatorial mode (cfgWord[0]=1), the output source is A when cfgWord[2:1]=0, A|B when it is 1, and A|B|C otherwise. Register 1's input is A|B (shared terms) and register 2's input is C.
- R5: A D-type register (cfgWord[5] for reg 1, cfgWord[6] for reg 2, 0 = D) loads its input only at a system edge where its effective clock rose. A clock held high gives one load only.
- R6: A T-type register (type bit 1) inverts at a clocking edge when its input is 1 and keeps its value when its input is 0.
- R7: The effective clock is the clock term alone when its gate bit is 0 (cfgWord[7] reg 1, cfgWord[8] reg 2). When the gate bit is 1 it is the clock term ANDed with pinClk.
- R8: A high reset term clears its register at the next system edge, with priority over clock, preset and data.
- R9: presetIn high at a clocking edge sets the register to 1, whatever its input and type (unless R8 applies).
- R10: padOut is the selected source (register 1 or the combinatorial sum) when cfgWord[4]=1, and its inverse when cfgWord[4]=0.
- R11: fb2Pair carries register 2's output when cfgWord[9]=0, and register 2's raw input when cfgWord[9]=1.
- R12: Each pair output carries the true value in bit 0 and its complement in bit 1. q1Pair reflects register 1 and pinPair reflects pinIn. padOe follows product term 4 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| pinClk | input | 1 | dedicated clock pin used for clock gating |
| pinIn | input | 1 | the cell's own pin input value |
| pterm | input | 17 | product terms from the array |
| presetIn | input | 1 | group synchronous preset |
| cfgWord | input | 10 | static configuration |
| padOut | output | 1 | value driven toward the pin |
| padOe | output | 1 | tri-state enable |
| q1Pair | output | 2 | register 1 feedback, true and complement |
| fb2Pair | output | 2 | second feedback, true and complement |
| pinPair | output | 2 | pin feedback, true and complement |

## Verification
Register 1 is visible on q1Pair one cycle after the edge that loads it. Register 2 is visible on fb2Pair the same way when the feedback selects its output. A wrong bit there shows on the first check after the faulty edge. A bad edge tracker shows as a second load while a clock term stays high, or as a missing load when the clock is gated. Bad steering or polarity shows on padOut in the same cycle as the product terms that exercise it.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  // configuration word, most significant field first (bit 9 down to bit 0)
  typedef struct packed {
    logic       fbRaw2;
    logic       gate2;
    logic       gate1;
    logic       tType2;
    logic       tType1;
    logic       polHigh;
    logic       regWide;
    logic [1:0] combWidth;
    logic       outComb;
  } cellCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] tick;
    logic [1:0] clr;
  } strobe_t;

  localparam int CTRL_TERMS = 5;
  localparam int NUM_SUMS   = 3;
  localparam int CFG_W      = $bits(cellCfg_t);
endpackage

// File: rtl/mcell_ctrl.sv
module mcell_ctrl
  import mcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pinClk,
  input  logic [1:0] clkTerm,
  input  logic [1:0] rstTerm,
  input  logic [1:0] gateSel,
  output strobe_t    stb
);
  logic [1:0] effClk;
  logic [1:0] prevClk;

  for (genvar r = 0; r < 2; r++) begin : g_clk
    assign effClk[r]   = clkTerm[r] & (gateSel[r] ? pinClk : 1'b1);
    assign stb.tick[r] = effClk[r] & ~prevClk[r];
    assign stb.clr[r]  = rstTerm[r];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prevClk[r] <= 1'b0;
      else        prevClk[r] <= effClk[r];
    end

    // R5: a held clock gives one tick only
    a_r5_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
      stb.tick[r] |=> !stb.tick[r]);
    // R7: gated clock cannot tick while the pin is low
    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (gateSel[r] && !pinClk) |-> !stb.tick[r]);
  end
endmodule

// File: rtl/mcell_dp.sv
module mcell_dp
  import mcell_pkg::*;
#(
  parameter int TERMS_PER_SUM = 4,
  localparam int SUM_W = NUM_SUMS * TERMS_PER_SUM
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] sumTerms,
  input  logic             oeTerm,
  input  logic             presetIn,
  input  logic             outComb,
  input  logic [1:0]       combWidth,
  input  logic             regWide,
  input  logic             polHigh,
  input  logic [1:0]       tType,
  input  logic             fbRaw2,
  input  strobe_t          stb,
  output logic             padOut,
  output logic             padOe,
  output logic [1:0]       q1Pair,
  output logic [1:0]       fb2Pair
);
  logic [NUM_SUMS-1:0] sumVal;
  logic [1:0]          dIn;
  logic [1:0]          qReg;
  logic                combVal;
  logic                srcVal;

  for (genvar g = 0; g < NUM_SUMS; g++) begin : g_sum
    assign sumVal[g] = |sumTerms[g*TERMS_PER_SUM +: TERMS_PER_SUM];
  end

  // term steering
  always_comb begin
    if (!outComb && regWide) dIn[0] = |sumVal;
    else                     dIn[0] = sumVal[0] | sumVal[1];
    dIn[1] = sumVal[2];
    case (combWidth)
      2'd0:    combVal = sumVal[0];
      2'd1:    combVal = sumVal[0] | sumVal[1];
      default: combVal = |sumVal;
    endcase
  end

  for (genvar r = 0; r < 2; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           qReg[r] <= 1'b0;
      else if (stb.clr[r])  qReg[r] <= 1'b0;
      else if (stb.tick[r]) begin
        if (presetIn)       qReg[r] <= 1'b1;
        else if (tType[r])  qReg[r] <= qReg[r] ^ dIn[r];
        else                qReg[r] <= dIn[r];
      end
    end

    // R8
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      stb.clr[r] |=> !qReg[r]);
    // R9
    a_r9_preset: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.tick[r] && !stb.clr[r] && presetIn) |=> qReg[r]);
    // R5
    a_r5_dload: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.tick[r] && !stb.clr[r] && !presetIn && !tType[r]) |=> qReg[r] == $past(dIn[r]));
    // R6
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.tick[r] && !stb.clr[r] && !presetIn && tType[r])
        |=> qReg[r] == ($past(qReg[r]) ^ $past(dIn[r])));
    // R5: no tick, no change
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb.tick[r] && !stb.clr[r]) |=> $stable(qReg[r]));
  end

  assign srcVal  = outComb ? combVal : qReg[0];
  assign padOut  = srcVal ^ ~polHigh;
  assign padOe   = oeTerm;
  assign q1Pair  = {~qReg[0], qReg[0]};
  assign fb2Pair = fbRaw2 ? {~dIn[1], dIn[1]} : {~qReg[1], qReg[1]};
endmodule

// File: rtl/mcell_macrocell.sv
module mcell_macrocell
  import mcell_pkg::*;
#(
  parameter int TERMS_PER_SUM = 4,
  localparam int PT_W = CTRL_TERMS + NUM_SUMS * TERMS_PER_SUM
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pinClk,
  input  logic            pinIn,
  input  logic [PT_W-1:0] pterm,
  input  logic            presetIn,
  input  logic [CFG_W-1:0] cfgWord,
  output logic            padOut,
  output logic            padOe,
  output logic [1:0]      q1Pair,
  output logic [1:0]      fb2Pair,
  output logic [1:0]      pinPair
);
  cellCfg_t cfg;
  strobe_t  stb;

  assign cfg     = cellCfg_t'(cfgWord);
  assign pinPair = {~pinIn, pinIn};

  mcell_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .pinClk  (pinClk),
    .clkTerm ({pterm[2], pterm[1]}),
    .rstTerm ({pterm[3], pterm[0]}),
    .gateSel ({cfg.gate2, cfg.gate1}),
    .stb     (stb)
  );

  mcell_dp #(.TERMS_PER_SUM(TERMS_PER_SUM)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sumTerms  (pterm[PT_W-1:CTRL_TERMS]),
    .oeTerm    (pterm[4]),
    .presetIn  (presetIn),
    .outComb   (cfg.outComb),
    .combWidth (cfg.combWidth),
    .regWide   (cfg.regWide),
    .polHigh   (cfg.polHigh),
    .tType     ({cfg.tType2, cfg.tType1}),
    .fbRaw2    (cfg.fbRaw2),
    .stb       (stb),
    .padOut    (padOut),
    .padOe     (padOe),
    .q1Pair    (q1Pair),
    .fb2Pair   (fb2Pair)
  );
endmodule

// File: tb/mcell_macrocell_test.sv
module mcell_macrocell_test;
  localparam logic [16:0] AR1 = 17'd1 << 0;
  localparam logic [16:0] CK1 = 17'd1 << 1;
  localparam logic [16:0] CK2 = 17'd1 << 2;
  localparam logic [16:0] AR2 = 17'd1 << 3;
  localparam logic [16:0] OE  = 17'd1 << 4;
  localparam logic [16:0] SA  = 17'd1 << 6;
  localparam logic [16:0] SB  = 17'd1 << 11;
  localparam logic [16:0] SC  = 17'd1 << 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pinClk, pinIn, presetIn, padOut, padOe;
  logic [16:0] pterm;
  logic [9:0]  cfgWord, cfgNext;
  logic [1:0]  q1Pair, fb2Pair, pinPair;

  mcell_macrocell uut (.*);

  typedef struct {
    logic [6:0] val;   // {padOut, padOe, q1Pair, fb2Pair} wait: pin pair added below
    logic [1:0] pin;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0, fails = 0;
  logic m1 = 0, m2 = 0, p1 = 0, p2 = 0;

  task automatic step(input logic [16:0] pt, input logic pre, input logic pc,
                      input logic pin, input string tag);
    logic sa, sb, sc, d1, d2, e1, e2, cmb, src;
    exp_t e;
    @(negedge clk);
    pterm = pt; presetIn = pre; pinClk = pc; pinIn = pin; cfgWord = cfgNext;
    sa = |pt[8:5]; sb = |pt[12:9]; sc = |pt[16:13];
    d1 = (!cfgNext[0] && cfgNext[3]) ? (sa | sb | sc) : (sa | sb);
    d2 = sc;
    e1 = pt[1] & (cfgNext[7] ? pc : 1'b1);
    e2 = pt[2] & (cfgNext[8] ? pc : 1'b1);
    if (pt[0]) m1 = 1'b0;
    else if (e1 && !p1) m1 = pre ? 1'b1 : (cfgNext[5] ? (m1 ^ d1) : d1);
    if (pt[3]) m2 = 1'b0;
    else if (e2 && !p2) m2 = pre ? 1'b1 : (cfgNext[6] ? (m2 ^ d2) : d2);
    p1 = e1; p2 = e2;
    case (cfgNext[2:1])
      2'd0:    cmb = sa;
      2'd1:    cmb = sa | sb;
      default: cmb = sa | sb | sc;
    endcase
    src = cfgNext[0] ? cmb : m1;
    e.val = {src ^ ~cfgNext[4], pt[4], ~m1, m1,
             cfgNext[9] ? ~d2 : ~m2, cfgNext[9] ? d2 : m2};
    e.pin = {~pin, pin};
    e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (expQ.size() > 0) begin
        exp_t e;
        logic [6:0] act;
        e = expQ.pop_front();
        act = {padOut, padOe, q1Pair, fb2Pair};
        checks++;
        if (act !== e.val || pinPair !== e.pin) begin
          fails++;
          $display("FAIL %s: actual %b/%b expected %b/%b", e.tag, act, pinPair, e.val, e.pin);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; pterm = '0; presetIn = 0; pinClk = 0; pinIn = 0;
    cfgNext = 10'b00_0001_0000; cfgWord = cfgNext;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    checks++;
    if ({padOut, q1Pair, fb2Pair} !== 5'b0_10_10) begin
      fails++;
      $display("FAIL R1 reset: actual %b expected 01010", {padOut, q1Pair, fb2Pair});
    end
    // R5 D-type edge behaviour, R2 term positions
    step(SA,       0, 0, 0, "R5 no clock hold");
    step(SA | CK1, 0, 0, 0, "R5 R2 load on rise");
    step(CK1,      0, 0, 1, "R5 held clock no reload");
    step(0,        0, 0, 1, "R5 clock low");
    step(CK1,      0, 0, 0, "R5 load zero");
    step(0,        0, 0, 0, "R3 idle");
    step(SB | CK1, 0, 0, 0, "R3 narrow uses B");
    step(0,        0, 0, 0, "R3 idle");
    step(SC | CK1 | CK2, 0, 0, 0, "R3 narrow C only to reg2");
    // R6 T-type on reg 2
    cfgNext = 10'b00_0101_0000;
    step(0,        0, 0, 0, "R6 idle");
    step(SC | CK2, 0, 0, 0, "R6 toggle");
    step(0,        0, 0, 0, "R6 idle");
    step(SC | CK2, 0, 0, 0, "R6 toggle back");
    step(0,        0, 0, 0, "R6 idle");
    step(CK2,      0, 0, 0, "R6 hold on zero input");
    // R9 preset and R8 reset
    step(0,        0, 0, 0, "R9 idle");
    step(CK1 | CK2, 1, 0, 0, "R9 preset both");
    step(0,        0, 0, 0, "R8 idle");
    step(CK1 | AR1 | SA, 1, 0, 0, "R8 reset beats preset");
    step(AR2,      0, 0, 0, "R8 reset without clock");
    // R7 gating reg 1
    cfgNext = 10'b00_1001_0000;
    step(SA | CK1, 0, 0, 0, "R7 gated pin low");
    step(SA | CK1, 0, 1, 0, "R7 pin rise clocks");
    step(0,        0, 1, 0, "R7 idle");
    // R3 wide
    cfgNext = 10'b00_0001_1000;
    step(SC | CK1 | AR2, 0, 0, 0, "R3 wide C to reg1");
    // R4 combinatorial, R10 polarity low, R12 oe
    cfgNext = 10'b00_0000_0001;
    step(SB | OE,  0, 0, 1, "R4 R10 width4 ignores B");
    cfgNext = 10'b00_0000_0011;
    step(SB | OE,  0, 0, 0, "R4 R10 width8");
    cfgNext = 10'b00_0000_0101;
    step(SC,       0, 0, 0, "R4 R12 width12 oe low");
    cfgNext = 10'b00_0001_0101;
    step(SB | CK1, 0, 0, 0, "R4 shared reg1 input");
    // R11 raw feedback
    cfgNext = 10'b10_0001_0000;
    step(SC,       0, 0, 0, "R11 raw input high");
    step(0,        0, 0, 0, "R11 raw input low");
    cfgNext = 10'b00_0001_0000;
    step(0,        0, 0, 1, "R11 R12 register view");
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule